// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Stage Unit

This block advances the path metrics of a Viterbi decoder by one trellis stage. It visits the butterflies of the trellis one after another. For butterfly i it takes the two predecessor metrics, d(i) and d(i+s/2), where s is the state count, and one branch metric a. From these it forms four candidates with a pair of add/subtract operations: d(i)+a, d(i)−a, d(i+s/2)+a and d(i+s/2)−a. A single compare stage then selects the surviving metric for new state 2i and for new state 2i+1. For each new state it keeps one bit that records which predecessor won. These bits are gathered into one word per stage so that a later traceback can use them.

The metrics are held in two internal banks. One bank is read during a stage and the other is written, and the two swap roles when the stage ends. A load port fills the current bank while the unit is idle. A monitor port reads the current bank back, with normalization already applied. After a stage, the unit subtracts the MSB weight from every metric when all new metrics have the MSB set, so the metrics never wrap.

The surrounding logic pulses `start` once per stage. It watches `bfly_idx` and presents the branch metric for that butterfly on `bm_in`. It collects `dec_word` when `dec_valid` pulses.

Top module: `acs_butterfly`

## Requirements
- R1: After reset, `busy`, `dec_valid` and `dec_word` are all 0.
- R2: The new metric of state 2i is the smaller of d(i)+a and d(i+s/2)−a.
- R3: The new metric of state 2i+1 is the smaller of d(i)−a and d(i+s/2)+a.
- R4: A candidate sum above 2^W−1 saturates to 2^W−1. A candidate difference below 0 clamps to 0.
- R5: On equal candidates, the candidate built from d(i) wins and the decision bit is 0. The decision bit is 1 only when the candidate built from d(i+s/2) is strictly smaller.
- R6: When a stage ends, `dec_valid` is high for exactly one cycle, and `busy` is already low in that cycle. Bit k of `dec_word` is the decision bit of new state k.
- R7: Each butterfly takes 4 cycles, so `busy` stays high for exactly 2·s cycles per stage (32 at the defaults). `bfly_idx` starts at 0 and holds steady during a butterfly. `bm_in` is sampled in the second cycle of each butterfly.
- R8: When every new metric of a stage has its MSB set, every metric read out of that bank has its MSB cleared. Otherwise the new metrics are read out unchanged.
- R9: While `busy` is high, `mon_data` still shows the previous stage's metrics, and `load_en` and `start` have no effect. When the stage ends, the new metrics appear on the monitor port and become the inputs of the next stage.
- R10: While idle, `load_en` writes `load_data` to state `load_addr` of the current bank and cancels any pending normalization of that bank. Reloading all states therefore reads back exactly the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one stage (honoured only while idle) |
| bm_in | input | W | Branch metric for butterfly `bfly_idx` |
| load_en | input | 1 | Write strobe for the current metric bank (idle only) |
| load_addr | input | log2(NS) | State index to load |
| load_data | input | W | Metric value to load |
| mon_addr | input | log2(NS) | State index to observe |
| mon_data | output | W | Current-bank metric of `mon_addr`, normalized |
| busy | output | 1 | Stage in progress |
| bfly_idx | output | log2(NS/2) | Butterfly being processed |
| dec_valid | output | 1 | One-cycle strobe for `dec_word` |
| dec_word | output | NS | Decision bits of the last stage, bit k for state k |

## Verification
A wrong pairing of predecessors, a wrong sign on the branch metric, or a reversed tie rule shows up in the next `dec_word` and in the metrics on the monitor port. Both are checked at the end of the same stage, about 2·s cycles after `start`. A fault in the bank swap or in the normalization flag corrupts every metric read on the monitor port right after the stage. It also spreads into the following stage, which the bench runs without reloading. A fault in sequencing changes the length of `busy`, which is counted cycle by cycle.

// File: rtl/acs_butterfly.sv
module acs_butterfly #(
  parameter int W  = 16,
  parameter int NS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [W-1:0]                   bm_in,
  input  logic                           load_en,
  input  logic [$clog2(NS)-1:0]          load_addr,
  input  logic [W-1:0]                   load_data,
  input  logic [$clog2(NS)-1:0]          mon_addr,
  output logic [W-1:0]                   mon_data,
  output logic                           busy,
  output logic [$clog2(NS/2)-1:0]        bfly_idx,
  output logic                           dec_valid,
  output logic [NS-1:0]                  dec_word
);
  localparam int AW   = $clog2(NS);
  localparam int HALF = NS / 2;
  localparam int BW   = $clog2(HALF);
  localparam logic [BW-1:0] LAST = BW'(HALF - 1);

  logic [W-1:0]  mem [2][NS];
  logic [1:0]    norm;
  logic          cur;
  logic [1:0]    phase;
  logic [W-1:0]  ma, mb, a;
  logic [NS-1:0] dec_acc, dec_next;
  logic          all_msb;

  function automatic logic [W-1:0] add_sat(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[W] ? {W{1'b1}} : s[W-1:0];
  endfunction

  function automatic logic [W-1:0] sub_sat(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x < y) ? '0 : x - y;
  endfunction

  wire [W-1:0]  cur_mask = ~{norm[cur], {(W-1){1'b0}}};
  wire [AW-1:0] rd_addr  = {phase[0], bfly_idx};
  wire [W-1:0]  old_val  = mem[cur][rd_addr] & cur_mask;
  wire [AW-1:0] wr_addr  = {bfly_idx, phase[0]};

  wire [W-1:0] cand_up = phase[0] ? sub_sat(ma, a) : add_sat(ma, a);
  wire [W-1:0] cand_lo = phase[0] ? add_sat(mb, a) : sub_sat(mb, a);
  wire         pick    = cand_lo < cand_up;
  wire [W-1:0] win     = pick ? cand_lo : cand_up;

  assign mon_data = mem[cur][mon_addr] & cur_mask;

  always_comb begin
    dec_next = dec_acc;
    dec_next[wr_addr] = pick;
  end

  always_ff @(posedge clk) begin
    if (!busy && load_en)
      mem[cur][load_addr] <= load_data;
    else if (busy && phase[1])
      mem[~cur][wr_addr] <= win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur       <= 1'b0;
      norm      <= '0;
      phase     <= '0;
      bfly_idx  <= '0;
      ma        <= '0;
      mb        <= '0;
      a         <= '0;
      dec_acc   <= '0;
      dec_word  <= '0;
      dec_valid <= 1'b0;
      all_msb   <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (!busy) begin
        if (load_en) norm[cur] <= 1'b0;
        if (start) begin
          busy     <= 1'b1;
          phase    <= '0;
          bfly_idx <= '0;
          all_msb  <= 1'b1;
        end
      end else begin
        phase <= phase + 2'd1;
        case (phase)
          2'd0: ma <= old_val;
          2'd1: begin mb <= old_val; a <= bm_in; end
          default: begin
            dec_acc <= dec_next;
            all_msb <= all_msb & win[W-1];
          end
        endcase
        if (phase == 2'd3) begin
          bfly_idx <= bfly_idx + 1'b1;
          if (bfly_idx == LAST) begin
            busy       <= 1'b0;
            cur        <= ~cur;
            norm[~cur] <= all_msb & win[W-1];
            dec_valid  <= 1'b1;
            dec_word   <= dec_next;
          end
        end
      end
    end
  end

  assert_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !busy);
  assert_stage_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bfly_idx == '0);
  assert_index_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != 2'd0) |-> $stable(bfly_idx));
  assert_bank_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(mon_addr)) |-> $stable(mon_data));
endmodule

// File: tb/acs_butterfly_test.sv
module acs_butterfly_test;
  localparam int PERIOD = 10;
  localparam int W  = 16;
  localparam int NS = 16;
  localparam int HALF = NS / 2;

  logic clk = 0, rst_n = 0, start = 0, load_en = 0;
  logic [W-1:0] bm_in = '0, load_data = '0;
  logic [3:0] load_addr = '0, mon_addr = '0;
  logic [W-1:0] mon_data;
  logic busy, dec_valid;
  logic [2:0] bfly_idx;
  logic [NS-1:0] dec_word;

  int errors = 0, checks = 0;
  logic [W-1:0] mdl [NS];
  logic [W-1:0] bm_tab [HALF];
  logic [NS-1:0] exp_q [$];
  int pulses = 0;

  acs_butterfly #(.W(W), .NS(NS)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] x, input logic [W-1:0] y);
    int s = int'(x) + int'(y);
    return (s > 65535) ? 16'hFFFF : W'(s);
  endfunction

  function automatic logic [W-1:0] sat_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    int s = int'(x) - int'(y);
    return (s < 0) ? 16'h0 : W'(s);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      bm_in = bm_tab[bfly_idx];
    end
  end

  initial begin
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (dec_valid) begin
        pulses++;
        check("R6 single-cycle strobe", prev, 1'b0);
        if (exp_q.size() == 0) check("R6 unexpected strobe", 1, 0);
        else check("R5/R6 decision word", dec_word, exp_q.pop_front());
      end
      prev = dec_valid;
    end
  end

  task automatic load_all;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      load_en = 1; load_addr = 4'(k); load_data = mdl[k];
    end
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic run_stage(input string req, input bit inject);
    logic [W-1:0] nxt [NS];
    logic [NS-1:0] dw = '0;
    bit allm = 1;
    int cnt = 0;
    logic [W-1:0] old5 = mdl[5];
    for (int i = 0; i < HALF; i++) begin
      logic [W-1:0] u0, l0, u1, l1;
      u0 = sat_add(mdl[i], bm_tab[i]); l0 = sat_sub(mdl[i+HALF], bm_tab[i]);
      u1 = sat_sub(mdl[i], bm_tab[i]); l1 = sat_add(mdl[i+HALF], bm_tab[i]);
      dw[2*i]   = l0 < u0; nxt[2*i]   = (l0 < u0) ? l0 : u0;
      dw[2*i+1] = l1 < u1; nxt[2*i+1] = (l1 < u1) ? l1 : u1;
    end
    for (int k = 0; k < NS; k++) allm &= nxt[k][W-1];
    for (int k = 0; k < NS; k++) mdl[k] = allm ? (nxt[k] & 16'h7FFF) : nxt[k];
    exp_q.push_back(dw);
    mon_addr = 4'd5;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy) begin
      cnt++;
      if (inject && cnt == 10) begin
        load_en = 1; load_addr = 4'd5; load_data = 16'h1234; start = 1;
        #1 check("R9 monitor shows old bank", mon_data, old5);
      end
      if (inject && cnt == 12) begin load_en = 0; start = 0; end
      @(negedge clk);
    end
    load_en = 0; start = 0;
    check("R7 busy length", cnt, 2*NS);
    @(negedge clk);
    check("R9 no restart", busy, 1'b0);
    for (int k = 0; k < NS; k++) begin
      mon_addr = 4'(k);
      #1 check(req, mon_data, mdl[k]);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < HALF; i++) bm_tab[i] = '0;
    #(PERIOD*2 + 2);
    check("R1 busy", busy, 0);
    check("R1 dec_valid", dec_valid, 0);
    check("R1 dec_word", dec_word, 0);
    rst_n = 1;

    for (int k = 0; k < NS; k++) mdl[k] = W'((k * 37 + 11) % 200);
    for (int i = 0; i < HALF; i++) bm_tab[i] = W'(i * 9 + 3);
    load_all();
    for (int k = 0; k < NS; k++) begin
      mon_addr = 4'(k);
      #1 check("R10 load readback", mon_data, mdl[k]);
    end
    run_stage("R2/R3 mixed metrics", 1);
    run_stage("R9 chained stage", 0);

    for (int k = 0; k < NS; k++) mdl[k] = (k < HALF) ? 16'd10 : 16'd20;
    for (int i = 0; i < HALF; i++) bm_tab[i] = 16'd5;
    load_all();
    run_stage("R5 tie stage", 0);

    for (int k = 0; k < NS; k++) mdl[k] = (k % 2) ? 16'hFFF0 : 16'h0008;
    for (int i = 0; i < HALF; i++) bm_tab[i] = 16'h0040;
    load_all();
    run_stage("R4 saturation", 0);

    for (int k = 0; k < NS; k++) mdl[k] = W'(16'h9000 + k * 16);
    for (int i = 0; i < HALF; i++) bm_tab[i] = W'(i + 1);
    load_all();
    run_stage("R8 normalized", 0);
    run_stage("R8 after normalization", 0);
    load_all();
    run_stage("R10 reload stage", 0);

    repeat (3) @(negedge clk);
    check("R6 strobe count", pulses, 7);
    check("R6 queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule